// File: doc/BRIEF.md
# Threshold-Driven Host Data FIFO

This block is the data buffer that sits between a processor's register port and the data path of a memory-card host. It holds up to 32 halfwords in a circular store. Software moves words in and out through a data register, and the card-side transfer engine uses the opposite end. Which side pushes and which side pops is set by the transfer direction. In the receive direction the card pushes and the CPU pops. In the transmit direction the CPU pushes and the card pops.

Two programmable levels watch the fill count. In the receive direction the concern is the buffer getting too full. In the transmit direction the concern is the buffer running low. When a level is crossed, the block raises one of two things, chosen per direction by a DMA enable bit: a DMA request line, or a status flag that software can poll. All four indications are registered. They are evaluated every cycle from the state the FIFO holds after that edge, so they always agree with the fill count shown on the same cycle. When no transfer is active and the FIFO is empty, all four are forced low. A transfer-start pulse empties the FIFO.

Top module: `hfifo_top`

## Requirements
- R1: Words leave in the order they entered. `head_data` always shows the oldest held word, and up to 32 words can be held.
- R2: A push while 32 words are held is dropped. `fill_count` stays at 32 and the stored words are unchanged.
- R3: A pop while the FIFO is empty has no effect. `fill_count` stays 0 and `head_data` keeps showing the entry at the head pointer.
- R4: When `xfer_dir`=1 (receive), pushes come from `card_push` with `card_wdata` and pops come from `cpu_rd`. When `xfer_dir`=0 (transmit), pushes come from `cpu_wr` with `cpu_wdata` and pops come from `card_pop`. Strobes from the other side are ignored.
- R5: The config word is laid out as follows. Bit 15 enables receive DMA. Bits 12:8 hold the high level. Bit 7 enables transmit DMA. Bits 4:0 hold the low level. Bits 14:13 and 6:5 read back 0. After reset the word reads 16'h1F00, which means a high level of 31, a low level of 0 and both DMA enables off.
- R6: With `xfer_dir`=1, if the count is greater than the high level, `rx_dma_req` goes high when receive DMA is enabled; otherwise `rx_level_flag` goes high. If the count is not greater than the high level, or the direction is 0, both are low.
- R7: With `xfer_dir`=0, if the count is less than the low level, `tx_dma_req` goes high when transmit DMA is enabled; otherwise `tx_level_flag` goes high. If the count is not less than the low level, or the direction is 1, both are low.
- R8: While `xfer_active`=0 and the FIFO is empty, all four indications are low.
- R9: A config write that enables a direction's DMA clears that direction's flag at the same edge that stores the write. If the level condition still holds, the request takes the flag's place at that same edge.
- R10: A `xfer_start` pulse empties the FIFO, and it takes precedence over any push or pop in the same cycle.
- R11: The indications are registered. They reflect the count, config, direction and activity in force after the same clock edge that updates `fill_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Pulse: empty the FIFO for a new data transfer |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = receive (card to CPU), 0 = transmit |
| cfg_wr | input | 1 | Write strobe for the config word |
| cfg_wdata | input | 16 | Config word to store |
| cfg_rdata | output | 16 | Stored config word |
| cpu_wr | input | 1 | CPU data-register write (push in transmit) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rd | input | 1 | CPU data-register read (pop in receive) |
| card_push | input | 1 | Card-side push (receive) |
| card_wdata | input | 16 | Card-side push data |
| card_pop | input | 1 | Card-side pop (transmit) |
| head_data | output | 16 | Oldest held word |
| fill_count | output | 6 | Number of held words, 0 to 32 |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_level_flag | output | 1 | Receive level status flag |
| tx_level_flag | output | 1 | Transmit level status flag |

## Verification
The bench builds the block with its defaults: 32 entries of 16 bits, with 5-bit level fields. At this size a full ring of 33 pushes followed by 33 pops fits in a few hundred cycles, so the test can reach the full-drop boundary, the empty-pop boundary and the wrap of the head pointer back to slot zero. The default depth also lets both extreme levels be programmed: a high level of 31 crossed only at a count of 32, and a low level of 0 that can never be crossed.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

    // Registered level indications
    typedef struct packed {
        logic rx_flag;
        logic rx_req;
        logic tx_flag;
        logic tx_req;
    } lvl_out_t;

endpackage

// File: rtl/hfifo_store.sv
module hfifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // Storage array: no reset, written only on an accepted push
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hfifo_ptr.sv
module hfifo_ptr #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    output logic          push_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] head_addr,
    output logic [CW-1:0] count_q_o,
    output logic [CW-1:0] count_nxt
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [CW-1:0] count;
    } ptr_t;

    ptr_t s_d, s_q;
    logic pop_ok;
    logic [AW:0] addr_sum;

    always_comb begin
        s_d      = s_q;
        push_ok  = push && (s_q.count != FULL);
        pop_ok   = pop && (s_q.count != '0);
        addr_sum = {1'b0, s_q.start} + (AW+1)'(s_q.count);
        if (addr_sum >= (AW+1)'(DEPTH)) begin
            addr_sum = addr_sum - (AW+1)'(DEPTH);
        end
        if (clear) begin
            s_d = '0;
        end else begin
            if (pop_ok) begin
                s_d.start = (s_q.start == AW'(DEPTH - 1)) ? '0 : s_q.start + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   s_d.count = s_q.count + 1'b1;
                2'b01:   s_d.count = s_q.count - 1'b1;
                default: s_d.count = s_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr   = addr_sum[AW-1:0];
    assign head_addr = s_q.start;
    assign count_q_o = s_q.count;
    assign count_nxt = s_d.count;

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= FULL) else $error("count beyond depth"); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == FULL && push && !pop && !clear) |=> (s_q.count == FULL))
        else $error("push into full ring changed count"); // R2

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.count == '0 && pop && !push && !clear) |=> (s_q.count == '0 && $stable(s_q.start)))
        else $error("pop from empty ring moved state"); // R3

    AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.count == '0)) else $error("start left entries"); // R10

endmodule

// File: rtl/hfifo_level.sv
module hfifo_level
    import hfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] hi_lvl,
    input  logic [AW-1:0] lo_lvl,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic          dir_rx,
    input  logic          active,
    output lvl_out_t      lvl
);

    logic over_hi, under_lo, idle_empty;

    always_comb begin
        over_hi    = dir_rx && (count > CW'(hi_lvl));
        under_lo   = !dir_rx && (count < CW'(lo_lvl));
        idle_empty = !active && (count == '0);
        lvl        = '0;
        if (!idle_empty) begin
            lvl.rx_req  = over_hi && rx_dma_en;
            lvl.rx_flag = over_hi && !rx_dma_en;
            lvl.tx_req  = under_lo && tx_dma_en;
            lvl.tx_flag = under_lo && !tx_dma_en;
        end
    end

endmodule

// File: rtl/hfifo_top.sv
module hfifo_top
    import hfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic          xfer_active,
    input  logic          xfer_dir,
    input  logic          cfg_wr,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          card_push,
    input  logic [DW-1:0] card_wdata,
    input  logic          card_pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill_count,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic          rx_level_flag,
    output logic          tx_level_flag
);

    localparam int HI_POS = 8;
    localparam int LO_POS = 0;

    typedef struct packed {
        logic          rx_en;
        logic [AW-1:0] hi;
        logic          tx_en;
        logic [AW-1:0] lo;
        lvl_out_t      lvl;
    } top_t;

    top_t st_d, st_q;

    logic          push, pop, push_ok;
    logic [DW-1:0] push_data;
    logic [AW-1:0] wr_addr, head_addr;
    logic [CW-1:0] count_q, count_nxt;
    lvl_out_t      lvl_nxt;

    // Direction routing of the two ends
    always_comb begin
        push      = xfer_dir ? card_push : cpu_wr;
        pop       = xfer_dir ? cpu_rd : card_pop;
        push_data = xfer_dir ? card_wdata : cpu_wdata;
    end

    hfifo_ptr #(.DEPTH(DEPTH)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .push      (push),
        .pop       (pop),
        .push_ok   (push_ok),
        .wr_addr   (wr_addr),
        .head_addr (head_addr),
        .count_q_o (count_q),
        .count_nxt (count_nxt)
    );

    hfifo_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk     (clk),
        .wr_en   (push_ok && !xfer_start),
        .wr_addr (wr_addr),
        .wr_data (push_data),
        .rd_addr (head_addr),
        .rd_data (head_data)
    );

    hfifo_level #(.DEPTH(DEPTH)) i_level (
        .count     (count_nxt),
        .hi_lvl    (st_d.hi),
        .lo_lvl    (st_d.lo),
        .rx_dma_en (st_d.rx_en),
        .tx_dma_en (st_d.tx_en),
        .dir_rx    (xfer_dir),
        .active    (xfer_active),
        .lvl       (lvl_nxt)
    );

    // Next state: config word, then indications from next-state values
    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.rx_en = cfg_wdata[15];
            st_d.hi    = cfg_wdata[HI_POS +: AW];
            st_d.tx_en = cfg_wdata[7];
            st_d.lo    = cfg_wdata[LO_POS +: AW];
        end
        st_d.lvl = lvl_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.hi    <= AW'(DEPTH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata                 = '0;
        cfg_rdata[15]             = st_q.rx_en;
        cfg_rdata[HI_POS +: AW]   = st_q.hi;
        cfg_rdata[7]              = st_q.tx_en;
        cfg_rdata[LO_POS +: AW]   = st_q.lo;
    end

    assign fill_count    = count_q;
    assign rx_dma_req    = st_q.lvl.rx_req;
    assign tx_dma_req    = st_q.lvl.tx_req;
    assign rx_level_flag = st_q.lvl.rx_flag;
    assign tx_level_flag = st_q.lvl.tx_flag;

    AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && rx_level_flag)) else $error("rx flag and request both high"); // R6

    AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && tx_level_flag)) else $error("tx flag and request both high"); // R7

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !((rx_dma_req || rx_level_flag) && (tx_dma_req || tx_level_flag)))
        else $error("both directions indicated"); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xfer_active) && fill_count == '0) |->
        !(rx_dma_req || tx_dma_req || rx_level_flag || tx_level_flag))
        else $error("indication while idle and empty"); // R8

    AST_DMA_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[15]) |=> !rx_level_flag)
        else $error("rx flag survived DMA enable"); // R9

endmodule

// File: tb/test_hfifo_top.sv
module test_hfifo_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 0, xfer_active = 0, xfer_dir = 0;
    logic        cfg_wr = 0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cpu_wr = 0, cpu_rd = 0, card_push = 0, card_pop = 0;
    logic [15:0] cpu_wdata = '0, card_wdata = '0;
    logic [15:0] head_data;
    logic [5:0]  fill_count;
    logic        rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    hfifo_top i_hfifo_top (
        .clk(clk), .rst_n(rst_n),
        .xfer_start(xfer_start), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .head_data(head_data), .fill_count(fill_count),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_level_flag(rx_level_flag), .tx_level_flag(tx_level_flag)
    );

    // cfg, dir, active, pushes, expected {rx_flag, rx_req, tx_flag, tx_req}
    typedef struct packed {
        logic [15:0] cfg;
        logic        dir;
        logic        act;
        logic [5:0]  n;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0300, 1'b1, 1'b1, 6'd4,  4'b1000},
        '{16'h0300, 1'b1, 1'b1, 6'd3,  4'b0000},
        '{16'h8300, 1'b1, 1'b1, 6'd4,  4'b0100},
        '{16'h0005, 1'b0, 1'b1, 6'd4,  4'b0010},
        '{16'h0085, 1'b0, 1'b1, 6'd4,  4'b0001},
        '{16'h0085, 1'b0, 1'b1, 6'd5,  4'b0000},
        '{16'h1F00, 1'b1, 1'b1, 6'd32, 4'b1000},
        '{16'h0000, 1'b0, 1'b1, 6'd0,  4'b0000},
        '{16'h0005, 1'b0, 1'b0, 6'd0,  4'b0000},
        '{16'h0005, 1'b0, 1'b1, 6'd0,  4'b0010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ind();
        return {rx_level_flag, rx_dma_req, tx_level_flag, tx_dma_req};
    endfunction

    task automatic restart();
        xfer_start = 1; @(negedge clk); xfer_start = 0;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
    endtask

    task automatic push_word(input logic [15:0] v);
        if (xfer_dir) begin card_push = 1; card_wdata = v; end
        else begin cpu_wr = 1; cpu_wdata = v; end
        @(negedge clk);
        card_push = 0; cpu_wr = 0;
    endtask

    task automatic pop_word();
        if (xfer_dir) cpu_rd = 1; else card_pop = 1;
        @(negedge clk);
        cpu_rd = 0; card_pop = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        chk("R5 reset config", cfg_rdata, 16'h1F00);
        chk("R1 reset empty", fill_count, 0);
        chk("R8 reset indications", ind(), 4'b0000);

        // Table walk: level crossings in both directions
        for (int v = 0; v < NV; v++) begin
            restart();
            write_cfg(VECS[v].cfg);
            xfer_dir = VECS[v].dir;
            xfer_active = VECS[v].act;
            @(negedge clk);
            for (int k = 0; k < int'(VECS[v].n); k++) push_word(16'h0100 + 16'(k));
            chk($sformatf("R6 R7 R8 vector %0d count", v), fill_count, VECS[v].n);
            chk($sformatf("R6 R7 R8 vector %0d indications", v), ind(), VECS[v].exp);
        end

        // R5 field layout readback
        write_cfg(16'hFFFF);
        chk("R5 readback", cfg_rdata, 16'h9F9F);

        // R11: indication changes at the edge that takes the count past the level
        restart();
        xfer_dir = 1; xfer_active = 1;
        write_cfg(16'h0300);
        for (int k = 0; k < 3; k++) push_word(16'h0200 + 16'(k));
        chk("R11 below level", ind(), 4'b0000);
        push_word(16'h0203);
        chk("R11 same edge as count", {fill_count, ind()}, {6'd4, 4'b1000});

        // R9: enabling DMA swaps flag for request at once
        write_cfg(16'h8300);
        chk("R9 rx enable", ind(), 4'b0100);

        // R1 receive side: CPU pops in order
        chk("R1 rx head", head_data, 16'h0200);
        pop_word();
        chk("R1 rx next head", head_data, 16'h0201);
        chk("R6 drop below level", ind(), 4'b0000);

        // R10 start empties
        restart();
        chk("R10 start empties", fill_count, 0);

        // R9 transmit side
        xfer_dir = 0;
        write_cfg(16'h0005);
        @(negedge clk);
        chk("R9 tx flag before", ind(), 4'b0010);
        write_cfg(16'h0085);
        chk("R9 tx enable", ind(), 4'b0001);

        // R4 off-direction strobes ignored
        card_push = 1; card_wdata = 16'hDEAD; @(negedge clk); card_push = 0;
        chk("R4 card push ignored in transmit", fill_count, 0);
        push_word(16'h5555);
        cpu_rd = 1; @(negedge clk); cpu_rd = 0;
        chk("R4 cpu read ignored in transmit", fill_count, 1);

        // R10 start with a simultaneous push
        xfer_start = 1; cpu_wr = 1; cpu_wdata = 16'h7777;
        @(negedge clk);
        xfer_start = 0; cpu_wr = 0;
        chk("R10 start beats push", fill_count, 0);

        // R2 full drop, R1 order and wrap, R3 empty pop
        write_cfg(16'h0000);
        for (int k = 0; k < 33; k++) push_word(16'hA000 + 16'(k));
        chk("R2 full holds 32", fill_count, 32);
        for (int k = 0; k < 32; k++) begin
            chk($sformatf("R1 order %0d", k), head_data, 16'hA000 + 16'(k));
            pop_word();
        end
        chk("R2 extra word was dropped", fill_count, 0);
        pop_word();
        chk("R3 empty pop count", fill_count, 0);
        chk("R3 empty pop head", head_data, 16'hA000);

        // R8 idle and empty after a transfer ends
        xfer_active = 0;
        write_cfg(16'h0005);
        chk("R8 idle empty quiet", ind(), 4'b0000);

        finish_run();
    end

endmodule